// File: doc/BRIEF.md
# Multi-Mode Serial Bit-Rate Strobe Generator

This block turns the peripheral clock into the timing strobes that one serial channel needs. A power-of-four prescaler, picked by a 2-bit clock-select field, feeds a reloadable 8-bit divider. A divide-by-two stage after the divider sets the common oversampling tick. An oversample counter turns ticks into bit-boundary strobes for asynchronous framing. In clocked synchronous mode a serial clock with 50% duty cycle toggles on every tick.

The host writes the divider value N through a simple write port and can read it back at any time. The clock-select value n, the mode (asynchronous or synchronous) and an extended-mode bit are level inputs. The extended-mode bit halves the asynchronous oversampling ratio. A divider write, or any change of these inputs, restarts every counter from zero, so the first period after a change has the full length. Each channel has its own instance, so channels can run at different rates.

Top module: `baud_strobe_gen`

## Requirements
- R1: The divider register `div_q` is 0xFF after reset. A cycle with `div_we` high loads `div_wdata`, and the new value is visible on `div_q` one clock later.
- R2: `clk_sel` value n (0 to 3, binary) scales every period by 4^n.
- R3: With T = 2 × 4^n × (N+1), `os_tick` is a one-cycle pulse. Counting the first clock edge after a restart as cycle 0, the pulse is high in cycles T, 2T, 3T and so on.
- R4: With `sync_mode`=0 and `ext_mode`=0, `bit_strobe` pulses in cycles 16T, 32T and so on, which is one bit every 32 × 4^n × (N+1) clocks. Each pulse falls together with an `os_tick` pulse.
- R5: With `sync_mode`=0 and `ext_mode`=1, `bit_strobe` pulses in cycles 8T, 16T and so on, which is one bit every 16 × 4^n × (N+1) clocks.
- R6: With `sync_mode`=1, `sclk_out` starts low and toggles in cycles T, 2T, 3T and so on, giving a period of 4 × 4^n × (N+1) clocks, and `bit_strobe` stays low. With `sync_mode`=0, `sclk_out` stays low.
- R7: A divider write, or a change of `clk_sel`, `sync_mode` or `ext_mode`, restarts the timing. The clock edge that sees the write or the change is the new cycle 0.
- R8: While `en` is low, `os_tick`, `bit_strobe` and `sclk_out` stay low. The first clock edge that sees `en` high is cycle 0.
- R9: The fastest setting (n=0, N=0) gives a tick every 2 clocks and a serial clock period of 4 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds all counters cleared |
| div_we | input | 1 | Divider register write strobe |
| div_wdata | input | 8 | Divider value N to write |
| div_q | output | 8 | Current divider value (readback) |
| clk_sel | input | 2 | Prescaler select n, divide by 4^n |
| sync_mode | input | 1 | 1 = clocked synchronous, 0 = asynchronous |
| ext_mode | input | 1 | Asynchronous extended mode: 8 ticks per bit instead of 16 |
| os_tick | output | 1 | Oversampling tick pulse |
| bit_strobe | output | 1 | Asynchronous bit-boundary pulse |
| sclk_out | output | 1 | Synchronous serial clock |

## Verification
The timing is tried under three patterns: fixed directed settings at the extremes (n=0 with N=0, n=3, N=255), random (n, N, mode, extended) combinations, and restarts injected in the middle of a period. The extremes show whether the prescaler and divider terminal counts are off by one. The random mixes show whether the tick, bit and serial-clock ratios are wired to the right mode. The mid-period restarts and the `en` gaps show whether a stale phase leaks into the first period after a change. Every output is compared each cycle with a count of cycles since the last restart.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic {
    MODE_ASYNC = 1'b0,
    MODE_SYNC  = 1'b1
  } serial_mode_e;

  // width of a counter that spans the largest power-of-four prescale
  function automatic int pre_width(input int sel_w);
    return 2 * ((1 << sel_w) - 1);
  endfunction
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int SEL_W = 2,
  localparam int CNT_W = baud_pkg::pre_width(SEL_W),
  localparam int NSEL  = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             step
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_tab [NSEL];

  // terminal count for each select value: 4^i - 1
  for (genvar i = 0; i < NSEL; i++) begin : g_last
    assign last_tab[i] = CNT_W'((1 << (2 * i)) - 1);
  end

  assign step = (cnt == last_tab[sel]);

  always_ff @(posedge clk) begin
    if (clr)       cnt <= '0;
    else if (step) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             step,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             half;
  logic             wrap;

  assign wrap = step && (cnt == reload);
  // tick on every second wrap: period 2 * (N+1) steps
  assign tick = wrap && half;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt  <= '0;
      half <= 1'b0;
    end else if (step) begin
      if (wrap) begin
        cnt  <= '0;
        half <= ~half;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/baud_oversampler.sv
module baud_oversampler #(
  parameter int OS_NORMAL = 16,
  parameter int OS_EXT    = 8,
  localparam int OS_W     = $clog2(OS_NORMAL)
) (
  input  logic clk,
  input  logic clr,
  input  logic tick,
  input  logic ext_mode,
  input  logic sync_mode,
  output logic os_tick,
  output logic bit_strobe,
  output logic sclk_out
);
  import baud_pkg::*;

  logic [OS_W-1:0] cnt;
  logic [OS_W-1:0] last;
  logic            bit_hit;
  serial_mode_e    mode;

  assign mode    = serial_mode_e'(sync_mode);
  assign last    = ext_mode ? OS_W'(OS_EXT - 1) : OS_W'(OS_NORMAL - 1);
  assign bit_hit = tick && (cnt == last);

  always_ff @(posedge clk) begin
    if (clr)          cnt <= '0;
    else if (bit_hit) cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      os_tick    <= 1'b0;
      bit_strobe <= 1'b0;
      sclk_out   <= 1'b0;
    end else begin
      os_tick    <= tick;
      bit_strobe <= bit_hit && (mode == MODE_ASYNC);
      if (mode == MODE_ASYNC) sclk_out <= 1'b0;
      else if (tick)          sclk_out <= ~sclk_out;
    end
  end
endmodule

// File: rtl/baud_strobe_gen.sv
module baud_strobe_gen #(
  parameter int DIV_W     = 8,
  parameter int SEL_W     = 2,
  parameter int OS_NORMAL = 16,
  parameter int OS_EXT    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic [DIV_W-1:0] div_q,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             sync_mode,
  input  logic             ext_mode,
  output logic             os_tick,
  output logic             bit_strobe,
  output logic             sclk_out
);
  logic [SEL_W-1:0] sel_q;
  logic             sync_q;
  logic             ext_q;
  logic             run_q;
  logic             cfg_change;
  logic             clr;
  logic             pre_step;
  logic             div_tick;

  always_ff @(posedge clk) begin
    if (rst)         div_q <= '1;
    else if (div_we) div_q <= div_wdata;
  end

  // previous configuration, used to spot a change
  always_ff @(posedge clk) begin
    sel_q  <= clk_sel;
    sync_q <= sync_mode;
    ext_q  <= ext_mode;
    run_q  <= rst ? 1'b0 : en;
  end

  assign cfg_change = (clk_sel != sel_q) || (sync_mode != sync_q) || (ext_mode != ext_q);
  assign clr        = rst || !en || !run_q || div_we || cfg_change;

  baud_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk  (clk),
    .clr  (clr),
    .sel  (clk_sel),
    .step (pre_step)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .clr    (clr),
    .step   (pre_step),
    .reload (div_q),
    .tick   (div_tick)
  );

  baud_oversampler #(.OS_NORMAL(OS_NORMAL), .OS_EXT(OS_EXT)) u_os (
    .clk        (clk),
    .clr        (clr),
    .tick       (div_tick),
    .ext_mode   (ext_mode),
    .sync_mode  (sync_mode),
    .os_tick    (os_tick),
    .bit_strobe (bit_strobe),
    .sclk_out   (sclk_out)
  );
endmodule

// File: rtl/baud_strobe_chk.sv
module baud_strobe_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             div_we,
  input logic [DIV_W-1:0] div_wdata,
  input logic [DIV_W-1:0] div_q,
  input logic             sync_mode,
  input logic             os_tick,
  input logic             bit_strobe,
  input logic             sclk_out
);
  logic rst_seen = 1'b0;

  always @(posedge clk) rst_seen <= rst;

  always @(posedge clk) begin
    if (rst_seen) AST_DIV_RESET: assert (div_q == '1); // R1
  end

  AST_DIV_LOAD: assert property (@(posedge clk) disable iff (rst)
    div_we |=> div_q == $past(div_wdata)); // R1
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (rst)
    os_tick |=> !os_tick); // R3
  AST_BIT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |-> os_tick); // R4
  AST_SYNC_NO_BIT: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |-> !$past(sync_mode)); // R6
  AST_ASYNC_SCLK_LOW: assert property (@(posedge clk) disable iff (rst)
    !sync_mode |=> !sclk_out); // R6
  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (rst)
    div_we |=> !os_tick && !bit_strobe); // R7
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> !os_tick && !bit_strobe && !sclk_out); // R8
endmodule

bind baud_strobe_gen baud_strobe_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .div_we     (div_we),
  .div_wdata  (div_wdata),
  .div_q      (div_q),
  .sync_mode  (sync_mode),
  .os_tick    (os_tick),
  .bit_strobe (bit_strobe),
  .sclk_out   (sclk_out)
);

// File: tb/tb_baud_strobe_gen.sv
`timescale 1ns/1ps
module tb_baud_strobe_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       div_we = 1'b0;
  logic [7:0] div_wdata = 8'h00;
  logic [7:0] div_q;
  logic [1:0] clk_sel = 2'd0;
  logic       sync_mode = 1'b0;
  logic       ext_mode = 1'b0;
  logic       os_tick, bit_strobe, sclk_out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  baud_strobe_gen dut (
    .clk(clk), .rst(rst), .en(en), .div_we(div_we), .div_wdata(div_wdata),
    .div_q(div_q), .clk_sel(clk_sel), .sync_mode(sync_mode), .ext_mode(ext_mode),
    .os_tick(os_tick), .bit_strobe(bit_strobe), .sclk_out(sclk_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      if (fails <= 20) $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int tick_period(input int n, input int nv);
    return 2 * (1 << (2 * n)) * (nv + 1);
  endfunction

  // compare the outputs each cycle against cycles since restart (k)
  task automatic run_ref(input int n, input int nv, input bit sm, input bit em, input int cycles);
    int t;
    int bp;
    t  = tick_period(n, nv);
    bp = t * (em ? 8 : 16);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      div_we = 1'b0;
      check("R2 R3 os_tick", int'(os_tick), int'(k > 0 && k % t == 0));
      if (em) check("R5 bit_strobe", int'(bit_strobe), int'(!sm && k > 0 && k % bp == 0));
      else    check("R4 bit_strobe", int'(bit_strobe), int'(!sm && k > 0 && k % bp == 0));
      check("R6 sclk_out", int'(sclk_out), int'(sm && ((k / t) % 2 == 1)));
    end
  endtask

  // drive a configuration at a negedge; the next edge is cycle 0
  task automatic configure(input int n, input int nv, input bit sm, input bit em, input bit wr);
    @(negedge clk);
    clk_sel   = 2'(n);
    sync_mode = sm;
    ext_mode  = em;
    if (wr) begin
      div_we    = 1'b1;
      div_wdata = 8'(nv);
    end
  endtask

  task automatic run_case(input int n, input int nv, input bit sm, input bit em, input int cycles);
    configure(n, nv, sm, em, 1'b1);
    run_ref(n, nv, sm, em, cycles);
  endtask

  initial begin
    int n, nv, cyc, bp;
    bit sm, em;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset div_q", int'(div_q), 255);
    check("R8 reset os_tick", int'(os_tick), 0);
    rst = 1'b0;
    en  = 1'b1;

    // R1 readback of a write
    configure(0, 8'h5A, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    div_we = 1'b0;
    check("R1 readback", int'(div_q), 8'h5A);

    // R9 fastest settings
    run_case(0, 0, 1'b0, 1'b0, 70);
    run_case(0, 0, 1'b1, 1'b0, 20);
    run_case(0, 0, 1'b0, 1'b1, 40);
    // R5 extended async
    run_case(1, 2, 1'b0, 1'b1, 400);
    // R4 with the largest prescale
    run_case(3, 3, 1'b0, 1'b0, 8200);
    // large divider value
    run_case(0, 255, 1'b0, 1'b0, 1100);
    // R6 sync with prescale
    run_case(2, 1, 1'b1, 1'b0, 300);

    // R7 restart by a rewrite of the same value mid-period
    run_case(0, 4, 1'b0, 1'b0, 37);
    run_case(0, 4, 1'b0, 1'b0, 200);
    // R7 restart by a select change alone
    configure(1, 4, 1'b0, 1'b0, 1'b0);
    run_ref(1, 4, 1'b0, 1'b0, 500);
    // R7 restart by a mode change alone
    configure(1, 4, 1'b1, 1'b0, 1'b0);
    run_ref(1, 4, 1'b1, 1'b0, 200);

    // R8 enable low holds outputs, rising edge restarts
    @(negedge clk);
    en = 1'b0;
    @(posedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check("R8 os_tick held", int'(os_tick), 0);
      check("R8 sclk held", int'(sclk_out), 0);
    end
    en = 1'b1;
    run_ref(1, 4, 1'b1, 1'b0, 200);

    // random mixes
    for (int it = 0; it < 14; it++) begin
      n  = int'($urandom_range(0, 2));
      nv = int'($urandom_range(0, 15));
      sm = 1'($urandom_range(0, 1));
      em = 1'($urandom_range(0, 1));
      bp = tick_period(n, nv) * (sm ? 2 : (em ? 8 : 16));
      cyc = 2 * bp + 3;
      if (cyc > 2500) cyc = 2500;
      run_case(n, nv, sm, em, cyc);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule